// File: doc/BRIEF.md
# Delayed-Writeback Execute Unit

This block is the execute stage of a small load/store processor core. Each cycle it can take one issued operation: add, subtract, multiply, or a word load that post-increments its pointer. All operands are read from a 16-entry, 32-bit register file in the issue cycle. Each operation class writes its destination a fixed number of cycles later. No interlock holds back a younger instruction, so software sees each class's latency directly. A younger instruction that reads a destination before that latency has run out gets the old value.

A load reads its pointer and offset registers in the issue cycle. In that same cycle it sends the pointer as a byte address to a synchronous word memory, and it writes back the pointer plus four times the offset. The returned word waits in an age-ordered queue of pending writes and commits four delay slots later. Multiply results use the same queue. Add and subtract results, and pointer updates, commit at the end of the issue cycle. A combinational peek port reads any register, so the state that a following instruction would see can be observed.

Top module: `dslot_exec_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all 16 registers to zero and drops every pending write. A load or multiply issued before the reset never writes its destination.
- R2: Operation code 0 (add) writes srcA+srcB (mod 2^32) to dst with zero delay slots. The instruction issued in the next cycle sees the sum.
- R3: Operation code 1 (subtract) writes srcA−srcB (mod 2^32) to dst with zero delay slots. For example, 0 − 1 gives 0xFFFFFFFF.
- R4: Operation code 2 (multiply) writes the low 32 bits of srcA×srcB to dst with one delay slot. The instruction in the next cycle sees the old value, and the one after that sees the product.
- R5: Operation code 3 (load) raises memRdEn in its issue cycle with memAddr equal to the pre-update pointer (register srcA). The word at memAddr[9:2] is written to dst after four delay slots. Instructions issued 1 to 4 cycles later see the old value, and one issued 5 cycles later sees the loaded word.
- R6: A load writes srcA ← srcA + (srcB << 2) in its issue cycle. For example, pointer 0x100 with offset 1 loads from 0x100 and leaves 0x104, and the next instruction sees 0x104.
- R7: Overwriting the pointer or offset register after a load's issue cycle changes neither that load's address nor its data.
- R8: A new operation is accepted in every cycle, including the cycle right after a load, with no stall.
- R9: When several writes reach the same register at the same clock edge, the most recently issued instruction's value is kept.
- R10: A cycle with issueValid low changes no register except through writes already pending, and keeps memRdEn low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issueValid | input | 1 | An operation is issued this cycle |
| issueOp | input | 2 | 0 add, 1 subtract, 2 multiply, 3 load |
| issueDst | input | 4 | Destination register index |
| issueSrcA | input | 4 | First source; pointer register for a load |
| issueSrcB | input | 4 | Second source; offset register for a load |
| memRdEn | output | 1 | Memory read request (load issue cycle) |
| memAddr | output | 32 | Byte address of the load |
| memRdData | input | 32 | Memory word, valid the cycle after memRdEn |
| peekIdx | input | 4 | Register index to observe |
| peekData | output | 32 | Current contents of register peekIdx |

## Verification
Relative to the issue cycle t, pointer updates and add/subtract results are due at the edge closing t. Multiply results are due at the edge closing t+1, and load data at the edge closing t+4. An instruction issued in cycle t+1, t+2 or t+5 respectively is therefore the first to see each result. The bench keeps a reference register file with a due-edge schedule for every pending write. It applies each edge's writes oldest first, just after that edge, and reads every register through the peek port on the falling edge. Targeted sequences check the old value in each delay slot, the new value on the first visible cycle, and collisions where a load, a multiply and an add land on one register at the same edge.

// File: rtl/dslot_pkg.sv
`timescale 1ns/1ps
package dslot_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_LDW = 2'd3
  } opKind_e;

  // strobes from control to datapath and write queue
  typedef struct packed {
    logic aluWe;   // zero-slot result written at end of issue cycle
    logic subSel;  // subtract instead of add
    logic qPush;   // result enters the pending-write queue
    logic qAwait;  // queued data comes from memory next cycle
    logic ptrWe;   // pointer post-increment written in issue cycle
    logic memRd;   // memory read request
  } strobe_t;

endpackage

// File: rtl/dslot_ctrl.sv
`timescale 1ns/1ps
module dslot_ctrl
  import dslot_pkg::*;
#(
  parameter int MUL_LAT  = 1,
  parameter int LOAD_LAT = 4,
  parameter int LATW     = 3
) (
  input  logic            issueValid,
  input  logic [1:0]      issueOp,
  output strobe_t         strobe,
  output logic [LATW-1:0] pushLat
);

  opKind_e opKind;

  always_comb begin
    opKind        = opKind_e'(issueOp);
    strobe        = '0;
    strobe.aluWe  = issueValid && (opKind == OP_ADD || opKind == OP_SUB);
    strobe.subSel = (opKind == OP_SUB);
    strobe.qPush  = issueValid && (opKind == OP_MUL || opKind == OP_LDW);
    strobe.qAwait = (opKind == OP_LDW);
    strobe.ptrWe  = issueValid && (opKind == OP_LDW);
    strobe.memRd  = issueValid && (opKind == OP_LDW);
    pushLat       = (opKind == OP_LDW) ? LATW'(LOAD_LAT) : LATW'(MUL_LAT);
  end

endmodule

// File: rtl/dslot_wbqueue.sv
`timescale 1ns/1ps
module dslot_wbqueue #(
  parameter int DW     = 32,
  parameter int IDXW   = 4,
  parameter int QDEPTH = 5,
  parameter int LATW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pushAwait,
  input  logic [LATW-1:0] pushLat,
  input  logic [IDXW-1:0] pushIdx,
  input  logic [DW-1:0]   pushData,
  input  logic [DW-1:0]   memRdData,
  output logic            cmtValid [QDEPTH],
  output logic [IDXW-1:0] cmtIdx   [QDEPTH],
  output logic [DW-1:0]   cmtData  [QDEPTH]
);

  // stage k holds the entry issued k+1 cycles ago; it commits when lat == k+1
  typedef struct packed {
    logic            valid;
    logic            await;
    logic [LATW-1:0] lat;
    logic [IDXW-1:0] idx;
    logic [DW-1:0]   data;
  } entry_t;

  entry_t stage [QDEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < QDEPTH; k++) stage[k] <= '0;
    end else begin
      stage[0].valid <= push;
      stage[0].await <= push && pushAwait;
      stage[0].lat   <= pushLat;
      stage[0].idx   <= pushIdx;
      stage[0].data  <= pushData;
      for (int k = 1; k < QDEPTH; k++) begin
        stage[k] <= stage[k-1];
        if (stage[k-1].lat == LATW'(k)) stage[k].valid <= 1'b0;
        if (stage[k-1].await) begin
          stage[k].data  <= memRdData;
          stage[k].await <= 1'b0;
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < QDEPTH; g++) begin : g_cmt
      assign cmtValid[g] = stage[g].valid && (stage[g].lat == LATW'(g + 1));
      assign cmtIdx[g]   = stage[g].idx;
      assign cmtData[g]  = stage[g].data;
    end
  endgenerate

endmodule

// File: rtl/dslot_datapath.sv
`timescale 1ns/1ps
module dslot_datapath
  import dslot_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NREG   = 16,
  parameter int IDXW   = 4,
  parameter int QDEPTH = 5,
  parameter int WSH    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  strobe_t         strobe,
  input  logic [IDXW-1:0] dst,
  input  logic [IDXW-1:0] srcA,
  input  logic [IDXW-1:0] srcB,
  input  logic [IDXW-1:0] peekIdx,
  input  logic            cmtValid [QDEPTH],
  input  logic [IDXW-1:0] cmtIdx   [QDEPTH],
  input  logic [DW-1:0]   cmtData  [QDEPTH],
  output logic [DW-1:0]   peekData,
  output logic [DW-1:0]   opA,
  output logic [DW-1:0]   opB,
  output logic [DW-1:0]   mulRes,
  output logic [DW-1:0]   memAddr
);

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] aluRes;
  logic [DW-1:0] ptrNext;

  assign opA      = regs[srcA];
  assign opB      = regs[srcB];
  assign aluRes   = strobe.subSel ? (opA - opB) : (opA + opB);
  assign mulRes   = opA * opB;
  assign ptrNext  = opA + (opB << WSH);
  assign memAddr  = opA;
  assign peekData = regs[peekIdx];

  // oldest writes first, issue-cycle writes last: the youngest value stays
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
    end else begin
      for (int k = QDEPTH - 1; k >= 0; k--) begin
        if (cmtValid[k]) regs[cmtIdx[k]] <= cmtData[k];
      end
      if (strobe.aluWe) regs[dst]  <= aluRes;
      if (strobe.ptrWe) regs[srcA] <= ptrNext;
    end
  end

endmodule

// File: rtl/dslot_exec_unit.sv
`timescale 1ns/1ps
module dslot_exec_unit
  import dslot_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NREG     = 16,
  parameter int MUL_LAT  = 1,
  parameter int LOAD_LAT = 4,
  parameter int QDEPTH   = 5,
  localparam int IDXW    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issueValid,
  input  logic [1:0]      issueOp,
  input  logic [IDXW-1:0] issueDst,
  input  logic [IDXW-1:0] issueSrcA,
  input  logic [IDXW-1:0] issueSrcB,
  output logic            memRdEn,
  output logic [DW-1:0]   memAddr,
  input  logic [DW-1:0]   memRdData,
  input  logic [IDXW-1:0] peekIdx,
  output logic [DW-1:0]   peekData
);

  localparam int LATW = $clog2(QDEPTH + 1);
  localparam int WSH  = $clog2(DW / 8);

  strobe_t         strobe;
  logic [LATW-1:0] pushLat;
  logic [DW-1:0]   opA;
  logic [DW-1:0]   opB;
  logic [DW-1:0]   mulRes;
  logic            cmtValid [QDEPTH];
  logic [IDXW-1:0] cmtIdx   [QDEPTH];
  logic [DW-1:0]   cmtData  [QDEPTH];

  assign memRdEn = strobe.memRd;

  dslot_ctrl #(.MUL_LAT(MUL_LAT), .LOAD_LAT(LOAD_LAT), .LATW(LATW)) u_ctrl (
    .issueValid(issueValid), .issueOp(issueOp), .strobe(strobe), .pushLat(pushLat)
  );

  dslot_wbqueue #(.DW(DW), .IDXW(IDXW), .QDEPTH(QDEPTH), .LATW(LATW)) u_queue (
    .clk(clk), .rst(rst), .push(strobe.qPush), .pushAwait(strobe.qAwait),
    .pushLat(pushLat), .pushIdx(issueDst), .pushData(mulRes), .memRdData(memRdData),
    .cmtValid(cmtValid), .cmtIdx(cmtIdx), .cmtData(cmtData)
  );

  dslot_datapath #(.DW(DW), .NREG(NREG), .IDXW(IDXW), .QDEPTH(QDEPTH), .WSH(WSH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .dst(issueDst), .srcA(issueSrcA),
    .srcB(issueSrcB), .peekIdx(peekIdx), .cmtValid(cmtValid), .cmtIdx(cmtIdx),
    .cmtData(cmtData), .peekData(peekData), .opA(opA), .opB(opB), .mulRes(mulRes),
    .memAddr(memAddr)
  );

endmodule

// File: rtl/dslot_checker.sv
`timescale 1ns/1ps
module dslot_checker
  import dslot_pkg::*;
#(
  parameter int DW   = 32,
  parameter int IDXW = 4,
  parameter int WSH  = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            issueValid,
  input logic [1:0]      issueOp,
  input logic [IDXW-1:0] issueDst,
  input logic [IDXW-1:0] issueSrcA,
  input logic [IDXW-1:0] peekIdx,
  input logic [DW-1:0]   peekData,
  input logic [DW-1:0]   opA,
  input logic [DW-1:0]   opB
);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> peekData == '0) else $error("reset left a register set"); // R1

  AST_ADD_NEXT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issueValid) && $past(issueOp) == OP_ADD && peekIdx == $past(issueDst))
    |-> peekData == $past(opA) + $past(opB)) else $error("add result not visible"); // R2

  AST_SUB_NEXT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issueValid) && $past(issueOp) == OP_SUB && peekIdx == $past(issueDst))
    |-> peekData == $past(opA) - $past(opB)) else $error("sub result not visible"); // R3

  AST_PTR_POSTINC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issueValid) && $past(issueOp) == OP_LDW && peekIdx == $past(issueSrcA))
    |-> peekData == $past(opA) + ($past(opB) << WSH)) else $error("pointer not updated"); // R6

endmodule

bind dslot_exec_unit dslot_checker #(.DW(DW), .IDXW(IDXW), .WSH(WSH)) u_chk (
  .clk(clk), .rst(rst), .issueValid(issueValid), .issueOp(issueOp), .issueDst(issueDst),
  .issueSrcA(issueSrcA), .peekIdx(peekIdx), .peekData(peekData), .opA(opA), .opB(opB)
);

// File: tb/dslot_exec_unit_tb.sv
`timescale 1ns/1ps
module dslot_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issueValid = 1'b0;
  logic [1:0]  issueOp = '0;
  logic [3:0]  issueDst = '0, issueSrcA = '0, issueSrcB = '0, peekIdx = '0;
  logic        memRdEn;
  logic [31:0] memAddr, memRdData, peekData;

  int checks = 0;
  int errors = 0;
  int edgeNo = 0;
  bit done   = 1'b0;

  logic [31:0] mReg [16];
  logic        pv   [8][3];   // class 0 load, 1 multiply, 2 issue-cycle
  logic [3:0]  pIdx [8][3];
  logic [31:0] pDat [8][3];

  always #5 clk = ~clk;

  dslot_exec_unit u_dut (
    .clk(clk), .rst(rst), .issueValid(issueValid), .issueOp(issueOp), .issueDst(issueDst),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .peekIdx(peekIdx), .peekData(peekData)
  );

  function automatic logic [31:0] memWord(input logic [7:0] w);
    if (w == 8'd0) return 32'd1;
    if (w == 8'd1) return 32'h100;
    return ({24'd0, w} * 32'h9E3779B1) ^ 32'h0BAD_F00D;
  endfunction

  always_ff @(posedge clk) if (memRdEn) memRdData <= memWord(memAddr[9:2]);

  task automatic clearModel();
    for (int i = 0; i < 16; i++) mReg[i] = '0;
    for (int s = 0; s < 8; s++) for (int c = 0; c < 3; c++) pv[s][c] = 1'b0;
  endtask

  task automatic sched(input int e, input int c, input logic [3:0] idx, input logic [31:0] d);
    pv[e % 8][c] = 1'b1; pIdx[e % 8][c] = idx; pDat[e % 8][c] = d;
  endtask

  task automatic applyEdge(input int e);
    for (int c = 0; c < 3; c++) if (pv[e % 8][c]) begin
      mReg[pIdx[e % 8][c]] = pDat[e % 8][c];
      pv[e % 8][c] = 1'b0;
    end
  endtask

  task automatic report(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic v, input logic [1:0] op, input logic [3:0] d, a, b);
    logic [31:0] va, vb;
    issueValid = v; issueOp = op; issueDst = d; issueSrcA = a; issueSrcB = b;
    va = mReg[a]; vb = mReg[b];
    #1;
    if (v) begin
      case (op)
        2'd0: sched(edgeNo, 2, d, va + vb);
        2'd1: sched(edgeNo, 2, d, va - vb);
        2'd2: sched(edgeNo + 1, 1, d, va * vb);
        default: begin
          sched(edgeNo, 2, a, va + (vb << 2));
          sched(edgeNo + 4, 0, d, memWord(va[9:2]));
          report("R5", "memRdEn", {31'd0, memRdEn}, 32'd1);
          report("R5", "memAddr", memAddr, va);
        end
      endcase
    end else begin
      report("R10", "memRdEn idle", {31'd0, memRdEn}, 32'd0);
    end
    @(posedge clk); #1;
    applyEdge(edgeNo);
    edgeNo++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 4'd0, 4'd0, 4'd0);
  endtask

  task automatic checkOne(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    peekIdx = idx; #0.1;
    report(tag, $sformatf("r%0d", idx), peekData, exp);
  endtask

  task automatic checkAll(input string tag);
    for (int i = 0; i < 16; i++) begin
      peekIdx = 4'(i); #0.1;
      report(tag, $sformatf("r%0d", i), peekData, mReg[i]);
    end
  endtask

  task automatic resetPulse();
    rst = 1'b1; issueValid = 1'b0;
    @(posedge clk); #1; clearModel();
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    clearModel();
    @(negedge clk);
    resetPulse();
    checkAll("R1");

    // R5: load r1 from address 0, old value in four slots, new in the fifth
    step(1'b1, 2'd3, 4'd1, 4'd0, 4'd0);
    for (int j = 1; j <= 5; j++) begin
      checkOne(4'd1, (j == 5) ? 32'd1 : 32'd0, "R5");
      if (j < 5) idle(1);
    end
    // R6 / R8: back-to-back loads, pointer r0 grows by 4*r1
    step(1'b1, 2'd3, 4'd3, 4'd0, 4'd1);
    checkOne(4'd0, 32'd4, "R6");
    step(1'b1, 2'd3, 4'd10, 4'd0, 4'd15);
    checkOne(4'd0, 32'd4, "R8");
    idle(4);
    checkOne(4'd10, 32'h100, "R5");
    checkOne(4'd3, 32'd1, "R8");

    // R6 / R7: pointer 0x100 offset 1, then clobber pointer and offset
    step(1'b1, 2'd3, 4'd9, 4'd10, 4'd1);
    checkOne(4'd10, 32'h104, "R6");
    step(1'b1, 2'd0, 4'd8, 4'd10, 4'd15);
    checkOne(4'd8, 32'h104, "R2");
    step(1'b1, 2'd1, 4'd10, 4'd10, 4'd10);
    checkOne(4'd10, 32'd0, "R3");
    step(1'b1, 2'd0, 4'd1, 4'd15, 4'd15);
    checkOne(4'd9, 32'd0, "R5");
    idle(1);
    checkOne(4'd9, memWord(8'd64), "R7");

    // R4: multiply one delay slot; R3 wrap
    step(1'b1, 2'd0, 4'd5, 4'd0, 4'd0);
    step(1'b1, 2'd2, 4'd6, 4'd5, 4'd0);
    checkOne(4'd6, 32'd0, "R4");
    idle(1);
    checkOne(4'd6, 32'd32, "R4");
    step(1'b1, 2'd1, 4'd7, 4'd15, 4'd3);
    checkOne(4'd7, 32'hFFFF_FFFF, "R3");

    // R9: load, multiply and add all land on r2 at one edge; add wins
    step(1'b1, 2'd3, 4'd2, 4'd0, 4'd15);
    idle(2);
    step(1'b1, 2'd2, 4'd2, 4'd5, 4'd5);
    step(1'b1, 2'd0, 4'd2, 4'd5, 4'd0);
    checkOne(4'd2, 32'd12, "R9");
    // R9: load and multiply land on r11; multiply wins
    step(1'b1, 2'd3, 4'd11, 4'd0, 4'd15);
    idle(2);
    step(1'b1, 2'd2, 4'd11, 4'd5, 4'd5);
    idle(1);
    checkOne(4'd11, 32'd64, "R9");
    checkAll("R10");
    idle(2);
    checkAll("R10");

    // R1: reset with a load and a multiply in flight
    step(1'b1, 2'd3, 4'd12, 4'd0, 4'd15);
    step(1'b1, 2'd2, 4'd13, 4'd5, 4'd5);
    resetPulse();
    checkAll("R1");
    for (int j = 0; j < 5; j++) begin
      idle(1);
      checkAll("R1");
    end

    // sweep: every op, register mix and collision pattern against the model
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0] | lfsr[1], lfsr[3:2], lfsr[7:4], lfsr[11:8], lfsr[15:12]);
      checkAll("R9");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule